// File: doc/BRIEF.md
# Card attribute register file

This block holds the small set of management registers that a removable flash card exposes in its attribute address plane. A host reaches them with byte reads and writes, and only while its attribute select is asserted. Two of the registers can only be written. One carries a soft-reset control for the flash devices. The other carries a power-down control for the same devices.

A third register can only be read. It reports both control bits and the combined ready state of every flash device. Software therefore reads this register to learn what it wrote into the write-only ones. The ready flag is the AND of the per-device ready lines. It passes through a two-flop synchronizer before it reaches the status byte.

The card reset pin is active high and asynchronous. It puts every register back to its power-on value. While it is held, it also keeps the devices in reset.

Top module: `card_attr_regs`

## Requirements
- R1: A write to attribute address 4000h takes bit 7 as the soft-reset control. From the next clock, `dev_reset` is 1 when that bit was 1 and 0 when it was 0. `dev_reset` keeps that value until 4000h is written again.
- R2: In a write to 4000h, bits 6 to 0 have no effect on any output or on the status byte.
- R3: A write to 4002h takes bit 2 as the power-down control. From the next clock, `dev_powerdown` equals that bit. Every other bit of the write has no effect.
- R4: A read strobe at 4100h returns the status byte on `rdata` one clock later. Bit 5 holds the soft-reset control and bit 3 holds the power-down control. Bit 0 is 1 when every device is ready. Bits 7, 6, 4, 2 and 1 are 0. In any cycle without a read strobe, `rdata` is 0 on the following clock.
- R5: The ready flag in status bit 0 is the AND of all `dev_ready` lines delayed by two clocks. For two clocks after reset it reads 0, meaning busy.
- R6: Reads of 4000h and 4002h return 0. A write to 4100h changes neither output nor the status byte.
- R7: An access is ignored when `attr_sel` is 0, and also when its address is none of the three register addresses, including the odd neighbours 4001h and 4101h. An ignored write leaves the outputs alone, and an ignored read returns 0.
- R8: While `rst_card` is 1, `dev_reset` is 1, `dev_powerdown` is 0 and `rdata` is 0. After release, both controls read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_card | input | 1 | Card reset pin, active high, asynchronous |
| attr_sel | input | 1 | Attribute plane select, 1 = register access allowed |
| wr_en | input | 1 | Host write strobe, one clock per write |
| rd_en | input | 1 | Host read strobe, one clock per read |
| addr | input | ADDR_W (15) | Attribute byte address |
| wdata | input | 8 | Write data byte |
| dev_ready | input | N_DEV (4) | Per-device ready lines, 1 = ready |
| rdata | output | 8 | Read data, valid the clock after the read strobe |
| dev_reset | output | 1 | Reset to all flash devices, active high |
| dev_powerdown | output | 1 | Power-down to all flash devices, active high |

## Verification
On every clock, the assertions check that a write to either control address shows up on its output one clock later, and that the controls stay still otherwise. They also check that `rdata` idles at 0 without a read, that reserved status bits stay clear, that the synchronized ready flag trails the device AND by two clocks, and that the card reset pin forces the safe output values. Some behaviour shows only in the bench's scenarios: the status byte mirroring each control bit, reads of write-only addresses returning 0, writes to the status address having no effect, and accesses without the attribute select or at odd addresses being ignored. These scenarios run against a clock-by-clock model.

// File: rtl/card_attr_pkg.sv
package card_attr_pkg;

    // Bit positions fixed by the host software view
    localparam int OPT_SRST_BIT  = 7;
    localparam int CFG_PD_BIT    = 2;
    localparam int STAT_SRST_BIT = 5;
    localparam int STAT_PD_BIT   = 3;
    localparam int STAT_RDY_BIT  = 0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_OPT  = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       soft_rst;
        logic       pwr_down;
        logic [7:0] rdata;
    } ctrl_state_t;

endpackage

// File: rtl/card_attr_decode.sv
module card_attr_decode
    import card_attr_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int OPT_ADDR  = 'h4000,
    parameter int CFG_ADDR  = 'h4002,
    parameter int STAT_ADDR = 'h4100
) (
    input  logic              attr_sel,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_ADDR);
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    always_comb begin
        sel = SEL_NONE;
        if (attr_sel) begin
            if (addr == OPT_A)       sel = SEL_OPT;
            else if (addr == CFG_A)  sel = SEL_CFG;
            else if (addr == STAT_A) sel = SEL_STAT;
        end
    end

endmodule

// File: rtl/card_attr_ready_sync.sv
module card_attr_ready_sync #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_card,
    input  logic [N_DEV-1:0] dev_ready,
    output logic             ready_s
);

    localparam int STAGES = 2;

    logic              all_rdy;
    logic [STAGES-1:0] sh_d, sh_q;
    logic [1:0]        age_d, age_q;

    always_comb begin
        all_rdy = &dev_ready;
        sh_d    = {sh_q[STAGES-2:0], all_rdy};
        age_d   = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    end

    always_ff @(posedge clk or posedge rst_card) begin
        if (rst_card) begin
            sh_q  <= '0;
            age_q <= '0;
        end else begin
            sh_q  <= sh_d;
            age_q <= age_d;
        end
    end

    assign ready_s = sh_q[STAGES-1];

    // R5: flag trails the device AND by two clocks once both stages are filled
    assert_ready_delay_R5: assert property (@(posedge clk) disable iff (rst_card)
        (age_q >= 2'd2) |-> (ready_s == $past(all_rdy, 2)));

    // R5: busy is reported until the pipeline has filled
    assert_ready_busy_after_reset_R5: assert property (@(posedge clk) disable iff (rst_card)
        (age_q == 2'd0) |-> !ready_s);

endmodule

// File: rtl/card_attr_regs.sv
module card_attr_regs
    import card_attr_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int N_DEV     = 4,
    parameter int OPT_ADDR  = 'h4000,
    parameter int CFG_ADDR  = 'h4002,
    parameter int STAT_ADDR = 'h4100
) (
    input  logic              clk,
    input  logic              rst_card,
    input  logic              attr_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [N_DEV-1:0]  dev_ready,
    output logic [7:0]        rdata,
    output logic              dev_reset,
    output logic              dev_powerdown
);

    reg_sel_e    sel;
    logic        ready_s;
    logic [7:0]  status;
    ctrl_state_t st_d, st_q;

    card_attr_decode #(
        .ADDR_W   (ADDR_W),
        .OPT_ADDR (OPT_ADDR),
        .CFG_ADDR (CFG_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .attr_sel(attr_sel),
        .addr    (addr),
        .sel     (sel)
    );

    card_attr_ready_sync #(
        .N_DEV(N_DEV)
    ) u_ready_sync (
        .clk      (clk),
        .rst_card (rst_card),
        .dev_ready(dev_ready),
        .ready_s  (ready_s)
    );

    always_comb begin
        status                = '0;
        status[STAT_SRST_BIT] = st_q.soft_rst;
        status[STAT_PD_BIT]   = st_q.pwr_down;
        status[STAT_RDY_BIT]  = ready_s;

        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_en) begin
            case (sel)
                SEL_OPT: st_d.soft_rst = wdata[OPT_SRST_BIT];
                SEL_CFG: st_d.pwr_down = wdata[CFG_PD_BIT];
                default: ;
            endcase
        end
        if (rd_en && (sel == SEL_STAT)) begin
            st_d.rdata = status;
        end
    end

    always_ff @(posedge clk or posedge rst_card) begin
        if (rst_card) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata         = st_q.rdata;
    assign dev_reset     = st_q.soft_rst | rst_card;
    assign dev_powerdown = st_q.pwr_down;

    localparam logic [ADDR_W-1:0] OPT_CHK  = ADDR_W'(OPT_ADDR);
    localparam logic [ADDR_W-1:0] CFG_CHK  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_CHK = ADDR_W'(STAT_ADDR);

    logic opt_wr_seen, cfg_wr_seen;
    assign opt_wr_seen = attr_sel && wr_en && (addr == OPT_CHK);
    assign cfg_wr_seen = attr_sel && wr_en && (addr == CFG_CHK);

    assert_opt_write_R1: assert property (@(posedge clk) disable iff (rst_card)
        opt_wr_seen |=> (dev_reset == $past(wdata[OPT_SRST_BIT])));

    assert_opt_hold_R1: assert property (@(posedge clk) disable iff (rst_card)
        !opt_wr_seen |=> $stable(dev_reset));

    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst_card)
        cfg_wr_seen |=> (dev_powerdown == $past(wdata[CFG_PD_BIT])));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst_card)
        !cfg_wr_seen |=> $stable(dev_powerdown));

    assert_rdata_idle_R4: assert property (@(posedge clk) disable iff (rst_card)
        !(attr_sel && rd_en) |=> (rdata == 8'h00));

    assert_reserved_clear_R4: assert property (@(posedge clk) disable iff (rst_card)
        (rdata & 8'hD6) == 8'h00);

    assert_status_write_R6: assert property (@(posedge clk) disable iff (rst_card)
        (attr_sel && wr_en && (addr == STAT_CHK)) |=> ($stable(dev_reset) && $stable(dev_powerdown)));

    assert_card_reset_R8: assert property (@(posedge clk)
        rst_card |-> (dev_reset && !dev_powerdown && (rdata == 8'h00)));

endmodule

// File: tb/card_attr_regs_bench.sv
module card_attr_regs_bench;

    localparam int AW = 15;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_card;
    logic          attr_sel, wr_en, rd_en;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [ND-1:0] dev_ready;
    logic [7:0]    rdata;
    logic          dev_reset, dev_powerdown;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    card_attr_regs #(.ADDR_W(AW), .N_DEV(ND)) u_card_attr_regs (
        .clk          (clk),
        .rst_card     (rst_card),
        .attr_sel     (attr_sel),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .dev_ready    (dev_ready),
        .rdata        (rdata),
        .dev_reset    (dev_reset),
        .dev_powerdown(dev_powerdown)
    );

    // Behavioural reference model
    bit       m_srst, m_pd;
    bit       m_rdy[$];
    int       m_rd;

    always @(posedge clk or posedge rst_card) begin
        if (rst_card) begin
            m_srst = 0; m_pd = 0; m_rd = 0;
            m_rdy  = '{0, 0};
        end else begin
            int nxt_rd;
            nxt_rd = 0;
            if (attr_sel && rd_en && addr == 15'h4100)
                nxt_rd = (m_srst ? 32 : 0) + (m_pd ? 8 : 0) + (m_rdy[0] ? 1 : 0);
            if (attr_sel && wr_en && addr == 15'h4000) m_srst = wdata[7];
            if (attr_sel && wr_en && addr == 15'h4002) m_pd   = wdata[2];
            void'(m_rdy.pop_front());
            m_rdy.push_back(&dev_ready);
            m_rd = nxt_rd;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Clock-by-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (!done) begin
            chk(rdata == 8'(m_rd), "R4 rdata vs model", int'(rdata), m_rd);
            chk(dev_reset == (m_srst || rst_card), "R1 dev_reset vs model",
                int'(dev_reset), int'(m_srst || rst_card));
            chk(dev_powerdown == m_pd, "R3 dev_powerdown vs model",
                int'(dev_powerdown), int'(m_pd));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        attr_sel = sel; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        attr_sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req,
                          input logic sel = 1'b1);
        @(negedge clk);
        attr_sel = sel; rd_en = 1'b1; addr = a;
        @(negedge clk);
        attr_sel = 1'b0; rd_en = 1'b0; addr = '0;
        #2;
        chk(rdata == exp, req, int'(rdata), int'(exp));
    endtask

    task automatic out_chk(input logic er, input logic ep, input string req);
        #2;
        chk(dev_reset == er, {req, " dev_reset"}, int'(dev_reset), int'(er));
        chk(dev_powerdown == ep, {req, " dev_powerdown"}, int'(dev_powerdown), int'(ep));
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_card = 1'b1; attr_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0; dev_ready = '1;
        repeat (3) @(negedge clk);
        // R8: reset state
        out_chk(1'b1, 1'b0, "R8 during reset");
        chk(rdata == 8'h00, "R8 rdata in reset", int'(rdata), 0);
        @(negedge clk);
        rst_card = 1'b0;
        out_chk(1'b0, 1'b0, "R8 after release");
        repeat (3) @(negedge clk);

        // R5/R4: all ready
        rd_chk(15'h4100, 8'h01, "R5 all ready status");

        // R1: soft reset set and cleared
        wr(15'h4000, 8'h80);
        out_chk(1'b1, 1'b0, "R1 soft reset set");
        rd_chk(15'h4100, 8'h21, "R4 status mirrors soft reset");
        repeat (4) @(negedge clk);
        out_chk(1'b1, 1'b0, "R1 soft reset held");
        // R2: low bits do not affect
        wr(15'h4000, 8'hFF);
        rd_chk(15'h4100, 8'h21, "R2 low bits ignored while set");
        wr(15'h4000, 8'h00);
        out_chk(1'b0, 1'b0, "R1 soft reset cleared");
        wr(15'h4000, 8'h7F);
        out_chk(1'b0, 1'b0, "R2 low bits ignored");
        rd_chk(15'h4100, 8'h01, "R2 status unchanged");

        // R3: power down
        wr(15'h4002, 8'h04);
        out_chk(1'b0, 1'b1, "R3 power down set");
        rd_chk(15'h4100, 8'h09, "R4 status mirrors power down");
        wr(15'h4002, 8'hFB);
        out_chk(1'b0, 1'b0, "R3 other bits ignored");

        // R5: one device goes busy; two-clock delay
        @(negedge clk);
        dev_ready = 4'b1011;
        attr_sel = 1'b1; rd_en = 1'b1; addr = 15'h4100;
        @(negedge clk);
        attr_sel = 1'b0; rd_en = 1'b0; addr = '0;
        #2 chk(rdata == 8'h01, "R5 busy not yet visible", int'(rdata), 1);
        rd_chk(15'h4100, 8'h00, "R5 busy after two clocks");
        @(negedge clk);
        dev_ready = '1;
        repeat (2) @(negedge clk);
        rd_chk(15'h4100, 8'h01, "R5 ready again");

        // R6: write-only reads, status writes
        wr(15'h4000, 8'h80);
        rd_chk(15'h4000, 8'h00, "R6 read of 4000h");
        rd_chk(15'h4002, 8'h00, "R6 read of 4002h");
        wr(15'h4100, 8'hFF);
        out_chk(1'b1, 1'b0, "R6 status write ignored");
        rd_chk(15'h4100, 8'h21, "R6 status after write");
        wr(15'h4000, 8'h00);

        // R7: no attribute select, odd addresses
        wr(15'h4000, 8'h80, 1'b0);
        out_chk(1'b0, 1'b0, "R7 write without attr_sel");
        wr(15'h4001, 8'h80);
        wr(15'h4003, 8'h04);
        out_chk(1'b0, 1'b0, "R7 odd address writes");
        rd_chk(15'h4100, 8'h00, "R7 read without attr_sel", 1'b0);
        rd_chk(15'h4101, 8'h00, "R7 odd status read");

        // R8: card reset clears both controls
        wr(15'h4000, 8'h80);
        wr(15'h4002, 8'h04);
        out_chk(1'b1, 1'b1, "R8 controls set");
        @(negedge clk);
        rst_card = 1'b1;
        out_chk(1'b1, 1'b0, "R8 card reset asserted");
        repeat (2) @(negedge clk);
        rst_card = 1'b0;
        out_chk(1'b0, 1'b0, "R8 defaults after release");
        rd_chk(15'h4100, 8'h00, "R5 busy right after reset");
        repeat (2) @(negedge clk);
        rd_chk(15'h4100, 8'h01, "R8 status defaults");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule